// File: doc/BRIEF.md
# CSR-Port Timer and Scratch Extension

This block hangs off a processor's fixed-timing CSR extension port and provides three 32-bit registers: a scratch word, a free-running time counter, and a compare value that drives a timer interrupt line. The port is split-phase. An address arrives one cycle ahead of the data phase and is held for five cycles. The block answers with a claim flag one cycle later. Read data returns one cycle after the read strobe. A write arrives in the sixth cycle with its final value, because any bit set or clear has already been merged upstream.

The port runs on a fixed schedule and has no handshake. The core never stalls the block, and the block never holds off the core. Every response therefore lands in a fixed cycle, and nothing is buffered. Software programs a relative delay by writing a tick count to the compare address. The block adds that count to the current time value. The interrupt stays high while the counter is at or above the compare value.

Top module: `tmr_csr_ext`

## Requirements
- R1: `csr_valid` is high in the cycle after `csr_addr` held 0xBC2 (compare), 0xBC3 (scratch) or 0xBC4 (time), and low in the cycle after any other address.
- R2: `csr_rdata` is zero in every cycle except the one directly after a cycle in which `csr_read` was high while `csr_valid` was high.
- R3: A write to 0xBC3 stores `csr_wdata` unchanged, and a later read of 0xBC3 returns it.
- R4: A write to 0xBC2 sets compare to the time value at that clock edge plus `csr_wdata`, modulo 2^32. A read of 0xBC2 returns compare.
- R5: The time counter, read at 0xBC4, advances by one on every clock and wraps from 0xFFFFFFFF to 0. Writes to it are ignored.
- R6: `timer_irq` is high exactly while time >= compare (unsigned). It falls when compare is rewritten to a larger value.
- R7: After reset, time equals the parameter `CNT_INIT` (default 0), scratch and `csr_rdata` are 0, `csr_valid` is low, and compare is 0xFFFFFFFF.
- R8: A write while `csr_valid` is low leaves scratch and compare unchanged. A read of an unclaimed address returns 0.
- R9: The write phase uses the decode of the address as it stood in the fifth cycle of the access. The address may already have changed in the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_read | input | 1 | Read strobe, second cycle of an access |
| csr_write | input | 1 | Write strobe, sixth cycle of an access |
| csr_wdata | input | 32 | Final write value |
| csr_addr | input | 12 | CSR number, one cycle ahead of the data phase |
| csr_rdata | output | 32 | Read data, non-zero for one cycle only |
| csr_valid | output | 1 | Address claimed by this block |
| timer_irq | output | 1 | Timer interrupt, level |

## Verification
The bench builds the block with `CNT_INIT` = 0xFFFFFF00 and keeps the default addresses. With that start value, the time counter passes 0xFFFFFFFF and wraps to zero within a few hundred cycles. This exercises the reset-time compare match and the interrupt dropping after the wrap without running for 2^32 cycles. The same run covers relative compare programming near the wrap point, reads of unclaimed addresses, and write cycles in which the address has already moved on.

// File: rtl/tmr_csr_pkg.sv
package tmr_csr_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CMP  = 2'd1,
    SEL_SCR  = 2'd2,
    SEL_TIME = 2'd3
  } sel_e;
endpackage

// File: rtl/tmr_csr_decode.sv
module tmr_csr_decode
  import tmr_csr_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter logic [11:0] ADDR_CMP  = 12'hBC2,
  parameter logic [11:0] ADDR_SCR  = 12'hBC3,
  parameter logic [11:0] ADDR_TIME = 12'hBC4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  output sel_e              sel_q
);
  sel_e sel_d;

  always_comb begin
    if (addr == ADDR_W'(ADDR_CMP))       sel_d = SEL_CMP;
    else if (addr == ADDR_W'(ADDR_SCR))  sel_d = SEL_SCR;
    else if (addr == ADDR_W'(ADDR_TIME)) sel_d = SEL_TIME;
    else                                 sel_d = SEL_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= SEL_NONE;
    else        sel_q <= sel_d;
  end
endmodule

// File: rtl/tmr_csr_timer.sv
module tmr_csr_timer #(
  parameter int               DATA_W   = 32,
  parameter logic [DATA_W-1:0] CNT_INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] time_q,
  output logic [DATA_W-1:0] cmp_q,
  output logic              irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) time_q <= CNT_INIT;
    else        time_q <= time_q + 1'b1;
  end

  // Compare is relative to the counter value at the write edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_q <= '1;
    else if (cmp_we) cmp_q <= time_q + wdata;
  end

  assign irq = (time_q >= cmp_q);
endmodule

// File: rtl/tmr_csr_scratch.sv
module tmr_csr_scratch #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] scr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  scr_q <= '0;
    else if (we) scr_q <= wdata;
  end
endmodule

// File: rtl/tmr_csr_ext.sv
module tmr_csr_ext
  import tmr_csr_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          ADDR_W    = 12,
  parameter logic [11:0] ADDR_CMP  = 12'hBC2,
  parameter logic [11:0] ADDR_SCR  = 12'hBC3,
  parameter logic [11:0] ADDR_TIME = 12'hBC4,
  parameter logic [31:0] CNT_INIT  = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_read,
  input  logic              csr_write,
  input  logic [DATA_W-1:0] csr_wdata,
  input  logic [ADDR_W-1:0] csr_addr,
  output logic [DATA_W-1:0] csr_rdata,
  output logic              csr_valid,
  output logic              timer_irq
);
  sel_e              sel_q;
  logic [DATA_W-1:0] time_w, cmp_w, scr_w;
  logic [DATA_W-1:0] rd_mux;
  logic              cmp_we, scr_we;

  tmr_csr_decode #(
    .ADDR_W(ADDR_W), .ADDR_CMP(ADDR_CMP), .ADDR_SCR(ADDR_SCR), .ADDR_TIME(ADDR_TIME)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(csr_addr), .sel_q(sel_q)
  );

  assign csr_valid = (sel_q != SEL_NONE);
  assign cmp_we    = csr_write && (sel_q == SEL_CMP);
  assign scr_we    = csr_write && (sel_q == SEL_SCR);

  tmr_csr_timer #(.DATA_W(DATA_W), .CNT_INIT(DATA_W'(CNT_INIT))) u_tmr (
    .clk(clk), .rst_n(rst_n), .cmp_we(cmp_we), .wdata(csr_wdata),
    .time_q(time_w), .cmp_q(cmp_w), .irq(timer_irq)
  );

  tmr_csr_scratch #(.DATA_W(DATA_W)) u_scr (
    .clk(clk), .rst_n(rst_n), .we(scr_we), .wdata(csr_wdata), .scr_q(scr_w)
  );

  always_comb begin
    unique case (sel_q)
      SEL_CMP:  rd_mux = cmp_w;
      SEL_SCR:  rd_mux = scr_w;
      SEL_TIME: rd_mux = time_w;
      default:  rd_mux = '0;
    endcase
  end

  // One-cycle read return, zero otherwise
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        csr_rdata <= '0;
    else if (csr_read) csr_rdata <= rd_mux;
    else               csr_rdata <= '0;
  end
endmodule

// File: rtl/tmr_csr_ext_chk.sv
module tmr_csr_ext_chk #(
  parameter int          DATA_W    = 32,
  parameter int          ADDR_W    = 12,
  parameter logic [11:0] ADDR_CMP  = 12'hBC2,
  parameter logic [11:0] ADDR_SCR  = 12'hBC3,
  parameter logic [11:0] ADDR_TIME = 12'hBC4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csr_read,
  input logic              csr_write,
  input logic [ADDR_W-1:0] csr_addr,
  input logic [DATA_W-1:0] csr_rdata,
  input logic              csr_valid,
  input logic [DATA_W-1:0] time_q,
  input logic [DATA_W-1:0] cmp_q,
  input logic [DATA_W-1:0] scr_q
);
  logic hit;
  assign hit = (csr_addr == ADDR_W'(ADDR_CMP)) || (csr_addr == ADDR_W'(ADDR_SCR)) ||
               (csr_addr == ADDR_W'(ADDR_TIME));

  // R1
  claim_chk: assert property (@(posedge clk) disable iff (!rst_n) hit |=> csr_valid);
  // R1
  no_claim_chk: assert property (@(posedge clk) disable iff (!rst_n) !hit |=> !csr_valid);
  // R2
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(csr_read && csr_valid) |=> (csr_rdata == '0));
  // R5
  time_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (time_q == $past(time_q) + 1'b1));
  // R3
  scr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_write |=> $stable(scr_q));
  // R8
  ignore_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_write && !csr_valid) |=> ($stable(scr_q) && $stable(cmp_q)));
endmodule

bind tmr_csr_ext tmr_csr_ext_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ADDR_CMP(ADDR_CMP), .ADDR_SCR(ADDR_SCR),
  .ADDR_TIME(ADDR_TIME)
) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_read(csr_read), .csr_write(csr_write),
  .csr_addr(csr_addr), .csr_rdata(csr_rdata), .csr_valid(csr_valid),
  .time_q(time_w), .cmp_q(cmp_w), .scr_q(scr_w)
);

// File: tb/tmr_csr_ext_tb.sv
module tmr_csr_ext_tb;
  localparam logic [31:0] START = 32'hFFFF_FF00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_read = 1'b0, csr_write = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_rdata;
  logic        csr_valid, timer_irq;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tmr_csr_ext #(.CNT_INIT(START)) u_dut (
    .clk(clk), .rst_n(rst_n), .csr_read(csr_read), .csr_write(csr_write),
    .csr_wdata(csr_wdata), .csr_addr(csr_addr), .csr_rdata(csr_rdata),
    .csr_valid(csr_valid), .timer_irq(timer_irq)
  );

  // Behavioural reference: 0 none, 1 compare, 2 scratch, 3 time
  int          m_sel = 0, m_last = 0;
  logic [31:0] m_time = START, m_cmp = '1, m_scr = '0, m_rdata = '0;

  function automatic int claim(input logic [11:0] a);
    if (a == 12'hBC2) return 1;
    if (a == 12'hBC3) return 2;
    if (a == 12'hBC4) return 3;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sel = 0; m_time = START; m_cmp = '1; m_scr = '0; m_rdata = '0;
    end else begin
      logic [31:0] v;
      case (m_sel)
        1: v = m_cmp;
        2: v = m_scr;
        3: v = m_time;
        default: v = '0;
      endcase
      m_rdata = (csr_read && m_sel != 0) ? v : 32'h0;
      if (csr_read) m_last = m_sel;
      if (csr_write && m_sel == 1) m_cmp = m_time + csr_wdata;
      if (csr_write && m_sel == 2) m_scr = csr_wdata;
      m_time = m_time + 1;
      m_sel = claim(csr_addr);
    end
  end

  function automatic string tag(input int s);
    case (s)
      1: return "R4";
      2: return "R3";
      3: return "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      check("R1 valid", {31'b0, csr_valid}, {31'b0, (m_sel != 0)});
      check({"R2 rdata ", tag(m_last)}, csr_rdata, m_rdata);
      check("R6 irq", {31'b0, timer_irq}, {31'b0, (m_time >= m_cmp)});
    end
    if (cyc > 100000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
      finish_run();
    end
  end

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic tick();
    @(negedge clk); #2;
  endtask

  // Full six-cycle access; addr moves away in the write cycle (R9)
  task automatic access(input logic [11:0] a, input bit rd, input bit wr, input logic [31:0] d);
    csr_addr = a; tick();
    csr_read = rd; tick();
    csr_read = 0; tick(); tick(); tick();
    csr_addr = 12'h000; csr_write = wr; csr_wdata = d; tick();
    csr_write = 0; csr_wdata = '0;
  endtask

  initial begin
    tick(); tick();
    // R7 reset values
    check("R7 rdata", csr_rdata, 32'h0);
    check("R7 valid", {31'b0, csr_valid}, 32'h0);
    check("R7 irq", {31'b0, timer_irq}, 32'h0);
    rst_n = 1; tick();
    access(12'hBC4, 1, 0, 0);                 // R5 time read
    access(12'hBC2, 1, 0, 0);                 // R7 compare all ones
    access(12'hBC3, 1, 0, 0);                 // R7 scratch zero
    access(12'hBC3, 0, 1, 32'hA5A5_1234);     // R3 / R9 write
    access(12'hBC3, 1, 0, 0);                 // R3 readback
    access(12'hBC4, 0, 1, 32'h1234);          // R5 time write ignored
    for (int i = 0; i < 300; i++) tick();     // R5 wrap, R6 irq at max then drop
    access(12'hBC4, 1, 0, 0);
    access(12'hBC2, 0, 1, 32'd20);            // R4 relative compare
    access(12'hBC2, 1, 0, 0);
    for (int i = 0; i < 30; i++) tick();      // R6 irq rises
    access(12'hBC2, 0, 1, 32'd5000);          // R6 irq falls
    access(12'h123, 1, 1, 32'hDEAD_BEEF);     // R8 unclaimed
    access(12'hBC3, 1, 0, 0);                 // R8 scratch unchanged
    access(12'hBC2, 1, 0, 0);                 // R8 compare unchanged
    csr_addr = 12'hBC3; tick(); tick(); csr_addr = 0; tick(); // R2 no read -> zero
    for (int i = 0; i < 60; i++) begin
      logic [11:0] a;
      case ($urandom_range(0, 3))
        0: a = 12'hBC2; 1: a = 12'hBC3; 2: a = 12'hBC4; default: a = 12'($urandom);
      endcase
      access(a, 1'($urandom), 1'($urandom), $urandom_range(0, 200));
    end
    tick(); tick();
    finish_run();
  end
endmodule